// File: doc/BRIEF.md
# Sequential Bubble Sorter

This block puts a fixed-size array of small unsigned values into ascending order. It does not build a wide single-cycle network. Instead it holds the array in a working register and examines one pair of neighbouring entries per clock. A start strobe loads the whole parallel input at once. The controller then walks a pair pointer across a window that shrinks by one position after every pass. It stops early as soon as a complete pass leaves the array unchanged. When the sort finishes, the ordered array is copied into a registered output bus, and a one-cycle completion pulse is issued with that copy.

An active-low enable stalls the block without touching the clock. While the enable is high, every register in the sort path holds its value, so a stall only lengthens the run. The controller has three states. `S_IDLE` waits for an accepted start and moves to `S_SORT` (transition *accept*). `S_SORT` performs one compare-and-swap per enabled cycle. At the end of each pass it either opens the next, shorter pass and stays in `S_SORT` (transition *next pass*), or moves to `S_DRAIN` (transition *finish*). It finishes when the pass made no swap or when the window has shrunk to a single pair. `S_DRAIN` loads the output register, pulses done, and returns to `S_IDLE` (transition *publish*).

Top module: `bsort_engine`

## Requirements
- R1: During and right after a synchronous reset (`rst_n` low), `busy` is 0, `done` is 0 and `dout` is all zeros.
- R2: A `start` sampled high at a clock edge while idle and with `en_n` low captures `din`, and `busy` reads 1 after that edge.
- R3: The published result is in ascending unsigned order, with entry i at bits [4i+3:4i] and the smallest value at entry 0.
- R4: Equal neighbours are never exchanged, so an array of all-equal entries finishes after a single pass of 15 comparisons.
- R5: Exactly one comparison is made per enabled cycle, and pass k (counted from 0) makes 15-k comparisons. `done` is seen exactly C+1 cycles after the start edge, where C is the total comparison count.
- R6: A pass that makes no swap ends the sort at once, so an already ascending input takes 15 comparisons.
- R7: No more than 15 passes are made, so a strictly descending input takes 120 comparisons.
- R8: `done` is high for exactly one cycle, in the same cycle in which `dout` takes the new result. At all other times `dout` holds its value.
- R9: A `start` pulse while `busy` is high is ignored, and the result is that of the array captured first.
- R10: While `en_n` is high, no state, pointer, array or output register changes. Each stalled cycle lengthens the run by one cycle, and `busy` stays high throughout.
- R11: A `start` pulse while idle with `en_n` high is ignored: `busy` stays 0 and `dout` is unchanged.
- R12: The pair pointer never passes the last pair of the current window, and never exceeds index 14.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_n | input | 1 | Active-low synchronous enable for all register updates |
| start | input | 1 | Begin a sort of `din` |
| din | input | 64 | Input array, entry i at bits [4i+3:4i] |
| busy | output | 1 | High from the accepted start until the return to idle |
| done | output | 1 | One-cycle pulse when `dout` is updated |
| dout | output | 64 | Registered sorted array, same packing as `din` |

## Verification
Several behaviours are checked by assertions on every cycle: the pointer staying inside the shrinking window, the freeze of controller state while the enable is high, `busy` rising after an accepted start, `done` lasting one cycle, `dout` changing only with `done`, and ascending order of every published result. Other behaviours can only be shown by the bench's scenarios, because they depend on the whole run rather than on any single cycle. These are the exact comparison count, and so the latency, for sorted, reversed, all-equal and swept inputs; the early stop; that a start arriving mid-sort is ignored; and that stalls lengthen the run by exactly their length.

// File: rtl/bsort_pkg.sv
package bsort_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SORT  = 2'd1,
        S_DRAIN = 2'd2
    } bs_state_t;

endpackage

// File: rtl/bsort_pair.sv
module bsort_pair #(
    parameter int N_ELEM = 16,
    parameter int ELEM_W = 4,
    localparam int IDX_W = $clog2(N_ELEM)
) (
    input  logic [N_ELEM*ELEM_W-1:0] arr,
    input  logic [IDX_W-1:0]         idx,
    output logic [ELEM_W-1:0]        lo,
    output logic [ELEM_W-1:0]        hi,
    output logic                     swap
);

    logic [ELEM_W-1:0] left_v;
    logic [ELEM_W-1:0] right_v;

    always_comb begin
        left_v  = arr[int'(idx)*ELEM_W +: ELEM_W];
        right_v = arr[(int'(idx)+1)*ELEM_W +: ELEM_W];
        // unsigned magnitude compare; ties keep their order
        swap    = (unsigned'(left_v) > unsigned'(right_v));
        lo      = swap ? right_v : left_v;
        hi      = swap ? left_v  : right_v;
    end

    always_comb begin
        AST_PAIR_ORDER: assert (lo <= hi); // R3
    end

endmodule

// File: rtl/bsort_ctrl.sv
module bsort_ctrl
    import bsort_pkg::*;
#(
    parameter int N_ELEM = 16,
    localparam int IDX_W = $clog2(N_ELEM),
    localparam logic [IDX_W-1:0] LAST0 = IDX_W'(N_ELEM - 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_n,
    input  logic             start,
    input  logic             swap,
    output logic [IDX_W-1:0] idx,
    output logic             load,
    output logic             do_cmp,
    output logic             drain,
    output logic             busy
);

    bs_state_t        state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [IDX_W-1:0] last_q, last_d;
    logic             any_q, any_d;
    logic             pass_end;
    logic             pass_swapped;

    always_comb begin
        state_d      = state_q;
        idx_d        = idx_q;
        last_d       = last_q;
        any_d        = any_q;
        pass_end     = (idx_q == last_q);
        pass_swapped = any_q | swap;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    state_d = S_SORT;
                    idx_d   = '0;
                    last_d  = LAST0;
                    any_d   = 1'b0;
                end
            end
            S_SORT: begin
                if (pass_end) begin
                    if (!pass_swapped || last_q == '0) begin
                        state_d = S_DRAIN;
                    end else begin
                        last_d = last_q - IDX_W'(1);
                        idx_d  = '0;
                        any_d  = 1'b0;
                    end
                end else begin
                    idx_d = idx_q + IDX_W'(1);
                    any_d = pass_swapped;
                end
            end
            S_DRAIN: begin
                state_d = S_IDLE;
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            last_q  <= LAST0;
            any_q   <= 1'b0;
        end else if (!en_n) begin
            state_q <= state_d;
            idx_q   <= idx_d;
            last_q  <= last_d;
            any_q   <= any_d;
        end
    end

    always_comb begin
        idx    = idx_q;
        load   = (state_q == S_IDLE)  && start && !en_n;
        do_cmp = (state_q == S_SORT)  && !en_n;
        drain  = (state_q == S_DRAIN) && !en_n;
        busy   = (state_q != S_IDLE);
    end

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SORT) |-> (idx_q <= last_q) && (last_q <= LAST0)); // R12

    AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |=> $stable(state_q) && $stable(idx_q) && $stable(last_q)); // R10

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !en_n) |=> busy); // R2

endmodule

// File: rtl/bsort_engine.sv
module bsort_engine #(
    parameter int N_ELEM = 16,
    parameter int ELEM_W = 4,
    localparam int IDX_W = $clog2(N_ELEM),
    localparam int BUS_W = N_ELEM * ELEM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_n,
    input  logic             start,
    input  logic [BUS_W-1:0] din,
    output logic             busy,
    output logic             done,
    output logic [BUS_W-1:0] dout
);

    logic [N_ELEM-1:0][ELEM_W-1:0] work_q;
    logic [BUS_W-1:0]              work_flat;
    logic [IDX_W-1:0]              idx;
    logic [IDX_W-1:0]              idx_nx;
    logic [ELEM_W-1:0]             lo, hi;
    logic                          swap, load, do_cmp, drain;
    logic [BUS_W-1:0]              dout_q;
    logic                          done_q;

    assign work_flat = work_q;
    assign idx_nx    = idx + IDX_W'(1);

    bsort_ctrl #(.N_ELEM(N_ELEM)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_n   (en_n),
        .start  (start),
        .swap   (swap),
        .idx    (idx),
        .load   (load),
        .do_cmp (do_cmp),
        .drain  (drain),
        .busy   (busy)
    );

    bsort_pair #(.N_ELEM(N_ELEM), .ELEM_W(ELEM_W)) u_pair (
        .arr  (work_flat),
        .idx  (idx),
        .lo   (lo),
        .hi   (hi),
        .swap (swap)
    );

    for (genvar g = 0; g < N_ELEM; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                work_q[g] <= '0;
            end else if (load) begin
                work_q[g] <= din[g*ELEM_W +: ELEM_W];
            end else if (do_cmp && idx == IDX_W'(g)) begin
                work_q[g] <= lo;
            end else if (do_cmp && idx_nx == IDX_W'(g)) begin
                work_q[g] <= hi;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= drain;
            if (drain) begin
                dout_q <= work_flat;
            end
        end
    end

    assign dout = dout_q;
    assign done = done_q;

    function automatic logic is_ascending(input logic [BUS_W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < N_ELEM - 1; i++) begin
            if (v[i*ELEM_W +: ELEM_W] > v[(i+1)*ELEM_W +: ELEM_W]) ok = 1'b0;
        end
        return ok;
    endfunction

    always_comb begin
        if (rst_n && done_q) begin
            AST_SORTED: assert (is_ascending(dout_q)); // R3
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout) |-> done); // R8

endmodule

// File: tb/sim_bsort_engine.sv
module sim_bsort_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] din = '0;
    logic        busy, done;
    logic [63:0] dout;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bsort_engine u0 (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .start(start),
        .din(din), .busy(busy), .done(done), .dout(dout)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int model(input logic [63:0] a, output logic [63:0] s);
        logic [3:0] v [16];
        logic [3:0] t;
        int c;
        bit sw;
        c = 0;
        for (int i = 0; i < 16; i++) v[i] = a[i*4 +: 4];
        for (int last = 14; last >= 0; last--) begin
            sw = 1'b0;
            for (int i = 0; i <= last; i++) begin
                c++;
                if (v[i] > v[i+1]) begin
                    t = v[i]; v[i] = v[i+1]; v[i+1] = t; sw = 1'b1;
                end
            end
            if (!sw) break;
        end
        for (int i = 0; i < 16; i++) s[i*4 +: 4] = v[i];
        return c;
    endfunction

    task automatic run_sort(input logic [63:0] a, input int frz_at, input int frz_len,
                            input bit mid_start, input string req);
        logic [63:0] exp_s;
        logic [63:0] held;
        int c;
        int n;
        c = model(a, exp_s);
        @(negedge clk);
        din = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        check(busy == 1'b1, "R2", 64'(busy), 64'd1);
        while (!done && n < 400) begin
            if (mid_start && n == 3) begin din = ~a; start = 1'b1; end
            else start = 1'b0;
            if (n == frz_at) en_n = 1'b1;
            if (n == frz_at + frz_len) en_n = 1'b0;
            @(negedge clk);
            n++;
            if (en_n) check(busy == 1'b1, "R10", 64'(busy), 64'd1);
        end
        start = 1'b0; en_n = 1'b0; din = a;
        // latency: C comparisons plus the drain cycle, plus any stall
        check(n == c + 1 + frz_len, req, 64'(n), 64'(c + 1 + frz_len));
        check(dout == exp_s, "R3", dout, exp_s);
        held = dout;
        @(negedge clk);
        check(done == 1'b0, "R8", 64'(done), 64'd0);
        check(dout == held, "R8", dout, held);
        check(busy == 1'b0, "R2", 64'(busy), 64'd0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] v;
        logic [63:0] held;
        logic [31:0] seed;
        seed = 32'h1234_5678;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 1'b0 && done == 1'b0, "R1", {62'd0, busy, done}, 64'd0);
        check(dout == '0, "R1", dout, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dout == '0 && !busy, "R1", dout, 64'd0);

        // R6: ascending input, one pass
        run_sort(64'hFEDC_BA98_7654_3210, -1, 0, 1'b0, "R6");
        // R4: all equal entries, one pass
        run_sort(64'h7777_7777_7777_7777, -1, 0, 1'b0, "R4");
        // R7 / R12: descending input, full shrinking window, 120 compares
        run_sort(64'h0123_4567_89AB_CDEF, -1, 0, 1'b0, "R7");
        // R9: start while busy ignored
        run_sort(64'h3A1F_0C92_5E7B_D648, -1, 0, 1'b1, "R9");
        // R10: stall mid-sort
        run_sort(64'h0123_4567_89AB_CDEF, 10, 7, 1'b0, "R10");
        run_sort(64'h5555_0000_FFFF_A5A5, 2, 3, 1'b0, "R10");

        // R11: start with enable high while idle
        held = dout;
        @(negedge clk);
        en_n = 1'b1; start = 1'b1; din = 64'h0;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        en_n = 1'b0;
        check(busy == 1'b0, "R11", 64'(busy), 64'd0);
        @(negedge clk);
        check(dout == held && !busy, "R11", dout, held);

        // R5: sweep single non-zero value over every value and position
        for (int val = 0; val < 16; val++) begin
            for (int p = 0; p < 16; p++) begin
                v = '0;
                v[p*4 +: 4] = 4'(val);
                run_sort(v, -1, 0, 1'b0, "R5");
            end
        end
        // R5: pseudo-random arrays
        for (int k = 0; k < 150; k++) begin
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            v[31:0] = seed;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            v[63:32] = seed;
            run_sort(v, -1, 0, 1'b0, "R5");
        end

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule